// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller with Row Refresh

This controller connects a simple single-bit host port to a 64K x 1 dynamic memory array. The array is organised as 256 rows by 256 columns and has only eight shared address pins. For each host request the controller splits the 16-bit address into two bytes. It presents the low byte with an active-low row strobe and then the high byte with an active-low column strobe. An active-low write-enable picks the direction. On a read, the controller captures the returned bit into a response register.

Dynamic cells leak, so every row must be restored within a fixed period. A free-running timer raises a refresh request once per interval, where the interval is the refresh period divided by the row count. A row counter supplies the row for each refresh, which is a row-strobe-only cycle. Refresh wins over host traffic only between host cycles. The host sees a ready/valid handshake and a host cycle is never cut short.

Top module: `dramc_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high (inactive), `req_ready` is 1 and `rsp_valid` is 0.
- R2: In a host cycle, the row strobe falls while `dram_addr` carries `req_addr[7:0]`. The row strobe falls before the column strobe.
- R3: In a host cycle, the column strobe falls while `dram_addr` carries `req_addr[15:8]`. The column strobe is low only while the row strobe is low, and `dram_addr` is stable while the column strobe stays low.
- R4: When the column strobe falls, `dram_we_n` is 0 for a write (`req_write`=1) and 1 for a read, and `dram_din` equals the write bit. `dram_we_n` does not change while the column strobe is low.
- R5: A read raises `rsp_valid` for exactly one cycle, with `rsp_rdata` equal to the bit last written at that address. `rsp_rdata` keeps its value through later writes until the next read completes.
- R6: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the following cycle and stays 0 whenever the row strobe is low.
- R7: A refresh pending flag is raised every REF_INTERVAL clock cycles after reset. Each refresh pulses only the row strobe, with the column strobe kept high. The refresh row starts at 0 after reset and advances by one, modulo 256, per refresh. With no host traffic, consecutive refresh row strobes fall exactly REF_INTERVAL cycles apart.
- R8: A pending refresh is started only between host cycles, and it goes ahead of a host request that is already waiting with `req_valid` high.
- R9: Under continuous host traffic no refresh tick is lost. Every row is restored within 256*REF_INTERVAL cycles plus one host cycle, so stored data survives in rows the host never touches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2*ROW_BITS | Bit address: low byte is the row, high byte is the column |
| req_wdata | input | 1 | Bit to store on a write |
| req_ready | output | 1 | Controller can take a request this cycle |
| rsp_valid | output | 1 | One-cycle pulse when read data is available |
| rsp_rdata | output | 1 | Last bit read, held between reads |
| dram_addr | output | ROW_BITS | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_din | output | 1 | Data bit to the array |
| dram_dout | input | 1 | Data bit from the array |

## Verification
Several rules are checked by assertions on every cycle. The column strobe may be low only inside a row strobe. Address and write-enable must hold steady while the column strobe is low. Ready must be low whenever the row strobe is down or a request has just been taken. The response pulse lasts a single cycle. The refresh row steps by one per refresh, and no timer tick may arrive while a refresh is still pending. Other behaviour shows up only in the bench scenarios: that the right byte is on the pins at each strobe edge, that refresh spacing equals the interval, that a waiting request is overtaken by a refresh, and that a bit per row survives two full refresh periods of traffic confined to four rows, judged against a leaking array model.

// File: rtl/dramc_pkg.sv
package dramc_pkg;

    // Sequencer phases; host cycles and refresh cycles share the precharge phase.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW,
        ST_RAS,
        ST_COL,
        ST_CAS,
        ST_PRE,
        ST_REF_ROW,
        ST_REF_RAS
    } dramc_state_e;

    // Which value the shared address pins carry.
    typedef enum logic [1:0] {
        SEL_ROW,
        SEL_COL,
        SEL_REF
    } dramc_asel_e;

endpackage

// File: rtl/dramc_refresh_timer.sv
module dramc_refresh_timer #(
    parameter int ROW_BITS     = 8,
    parameter int REF_INTERVAL = 1953
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_start,
    input  logic                ref_done,
    output logic                ref_pending,
    output logic [ROW_BITS-1:0] ref_row
);

    localparam int TCW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;

    typedef struct packed {
        logic [TCW-1:0]      cnt;
        logic                pending;
        logic [ROW_BITS-1:0] row;
    } tmr_t;

    localparam tmr_t TMR_RST = '{cnt: '0, pending: 1'b0, row: '0};

    tmr_t tmr_q, tmr_d;
    logic tick;

    always_comb begin
        tmr_d = tmr_q;
        tick  = (tmr_q.cnt == TCW'(REF_INTERVAL - 1));
        tmr_d.cnt     = tick ? '0 : tmr_q.cnt + TCW'(1);
        // A fresh tick re-arms the flag even in the cycle it is consumed.
        tmr_d.pending = tick | (tmr_q.pending & ~ref_start);
        if (ref_done) begin
            tmr_d.row = tmr_q.row + ROW_BITS'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= TMR_RST;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign ref_pending = tmr_q.pending;
    assign ref_row     = tmr_q.row;

    // R7: the refresh row advances by exactly one per completed refresh
    assert_row_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> (tmr_q.row == ROW_BITS'($past(tmr_q.row) + 1'b1)));

    // R9: a tick must never land on a request that is still waiting
    assert_no_lost_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (!tmr_q.pending || ref_start));

endmodule

// File: rtl/dramc_addr_mux.sv
module dramc_addr_mux
    import dramc_pkg::*;
#(
    parameter int ROW_BITS = 8
) (
    input  dramc_asel_e         sel,
    input  logic [ROW_BITS-1:0] row_half,
    input  logic [ROW_BITS-1:0] col_half,
    input  logic [ROW_BITS-1:0] ref_row,
    output logic [ROW_BITS-1:0] pin_addr
);

    always_comb begin
        case (sel)
            SEL_COL: pin_addr = col_half;
            SEL_REF: pin_addr = ref_row;
            default: pin_addr = row_half;
        endcase
    end

endmodule

// File: rtl/dramc_seq.sv
module dramc_seq
    import dramc_pkg::*;
#(
    parameter int ROW_BITS    = 8,
    parameter int RCD_CYC     = 2,
    parameter int CAS_CYC     = 2,
    parameter int PRE_CYC     = 2,
    parameter int REF_RAS_CYC = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*ROW_BITS-1:0] req_addr,
    input  logic                  req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic                  rsp_rdata,
    input  logic                  ref_pending,
    output logic                  ref_start,
    output logic                  ref_done,
    input  logic                  dram_dout,
    output logic                  ras_n,
    output logic                  cas_n,
    output logic                  we_n,
    output logic                  din,
    output dramc_asel_e           addr_sel,
    output logic [ROW_BITS-1:0]   row_half,
    output logic [ROW_BITS-1:0]   col_half
);

    localparam int ADDR_W = 2 * ROW_BITS;
    localparam int MAX_A  = (RCD_CYC > CAS_CYC) ? RCD_CYC : CAS_CYC;
    localparam int MAX_B  = (PRE_CYC > REF_RAS_CYC) ? PRE_CYC : REF_RAS_CYC;
    localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;

    typedef struct packed {
        dramc_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic              wdata;
        logic              rdata;
        logic              rsp;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, cnt: '0, wr: 1'b0, addr: '0,
                                 wdata: 1'b0, rdata: 1'b0, rsp: 1'b0};

    seq_t seq_q, seq_d;

    // Next-state computation: one phase counter serves every timed phase.
    always_comb begin
        seq_d     = seq_q;
        seq_d.rsp = 1'b0;
        ref_start = 1'b0;
        ref_done  = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (ref_pending) begin
                    seq_d.st  = ST_REF_ROW;
                    ref_start = 1'b1;
                end else if (req_valid) begin
                    seq_d.st    = ST_ROW;
                    seq_d.wr    = req_write;
                    seq_d.addr  = req_addr;
                    seq_d.wdata = req_wdata;
                end
            end
            ST_ROW: begin
                seq_d.st  = ST_RAS;
                seq_d.cnt = CNT_W'(RCD_CYC - 1);
            end
            ST_RAS: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_COL;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_COL: begin
                seq_d.st  = ST_CAS;
                seq_d.cnt = CNT_W'(CAS_CYC - 1);
            end
            ST_CAS: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_PRE;
                    seq_d.cnt = CNT_W'(PRE_CYC - 1);
                    if (!seq_q.wr) begin
                        seq_d.rdata = dram_dout;
                        seq_d.rsp   = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            ST_REF_ROW: begin
                seq_d.st  = ST_REF_RAS;
                seq_d.cnt = CNT_W'(REF_RAS_CYC - 1);
            end
            ST_REF_RAS: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st  = ST_PRE;
                    seq_d.cnt = CNT_W'(PRE_CYC - 1);
                    ref_done  = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    // Strobe and select decode from the registered phase only.
    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        addr_sel = SEL_ROW;
        case (seq_q.st)
            ST_RAS: ras_n = 1'b0;
            ST_COL: begin
                ras_n    = 1'b0;
                we_n     = ~seq_q.wr;
                addr_sel = SEL_COL;
            end
            ST_CAS: begin
                ras_n    = 1'b0;
                cas_n    = 1'b0;
                we_n     = ~seq_q.wr;
                addr_sel = SEL_COL;
            end
            ST_REF_ROW: addr_sel = SEL_REF;
            ST_REF_RAS: begin
                ras_n    = 1'b0;
                addr_sel = SEL_REF;
            end
            default: ;
        endcase
    end

    assign req_ready = (seq_q.st == ST_IDLE) && !ref_pending;
    assign rsp_valid = seq_q.rsp;
    assign rsp_rdata = seq_q.rdata;
    assign din       = seq_q.wdata;
    assign row_half  = seq_q.addr[ROW_BITS-1:0];
    assign col_half  = seq_q.addr[ADDR_W-1:ROW_BITS];

    // R3: column strobe only inside an open row
    assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R4: write-enable held while the column strobe is low
    assert_we_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && $past(!cas_n)) |-> $stable(we_n));

    // R5: read response lasts one cycle
    assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R6: busy right after a request is taken
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6: never ready while a row is open
    assert_busy_in_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> !req_ready);

endmodule

// File: rtl/dramc_top.sv
module dramc_top
    import dramc_pkg::*;
#(
    parameter int ROW_BITS     = 8,
    parameter int REF_INTERVAL = 1953,
    parameter int RCD_CYC      = 2,
    parameter int CAS_CYC      = 2,
    parameter int PRE_CYC      = 2,
    parameter int REF_RAS_CYC  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [2*ROW_BITS-1:0] req_addr,
    input  logic                  req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic                  rsp_rdata,
    output logic [ROW_BITS-1:0]   dram_addr,
    output logic                  dram_ras_n,
    output logic                  dram_cas_n,
    output logic                  dram_we_n,
    output logic                  dram_din,
    input  logic                  dram_dout
);

    logic                ref_pending;
    logic                ref_start;
    logic                ref_done;
    logic [ROW_BITS-1:0] ref_row;
    logic [ROW_BITS-1:0] row_half;
    logic [ROW_BITS-1:0] col_half;
    dramc_asel_e         addr_sel;

    dramc_refresh_timer #(
        .ROW_BITS     (ROW_BITS),
        .REF_INTERVAL (REF_INTERVAL)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_start   (ref_start),
        .ref_done    (ref_done),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    dramc_seq #(
        .ROW_BITS    (ROW_BITS),
        .RCD_CYC     (RCD_CYC),
        .CAS_CYC     (CAS_CYC),
        .PRE_CYC     (PRE_CYC),
        .REF_RAS_CYC (REF_RAS_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_ready   (req_ready),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .ref_pending (ref_pending),
        .ref_start   (ref_start),
        .ref_done    (ref_done),
        .dram_dout   (dram_dout),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .din         (dram_din),
        .addr_sel    (addr_sel),
        .row_half    (row_half),
        .col_half    (col_half)
    );

    dramc_addr_mux #(
        .ROW_BITS (ROW_BITS)
    ) u_amux (
        .sel      (addr_sel),
        .row_half (row_half),
        .col_half (col_half),
        .ref_row  (ref_row),
        .pin_addr (dram_addr)
    );

    // R3: column address held on the pins while the column strobe is low
    assert_col_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));

endmodule

// File: tb/dramc_array_model.sv
module dramc_array_model #(
    parameter int     ROW_BITS = 8,
    parameter longint LIMIT    = 6208
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ROW_BITS-1:0] addr,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                din,
    output logic                dout,
    output int                  corrupt_events
);

    localparam int N = 1 << ROW_BITS;

    logic [N-1:0]        mem [N];
    longint              last_ref [N];
    longint              cyc;
    logic [ROW_BITS-1:0] open_row;
    logic                ras_p;
    logic                cas_p;

    // Any row strobe restores its row; a row left too long loses its data.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc            <= 0;
            ras_p          <= 1'b1;
            cas_p          <= 1'b1;
            open_row       <= '0;
            corrupt_events <= 0;
            for (int r = 0; r < N; r++) begin
                mem[r]      <= '0;
                last_ref[r] <= 0;
            end
        end else begin
            cyc   <= cyc + 1;
            ras_p <= ras_n;
            cas_p <= cas_n;
            if (ras_p && !ras_n) begin
                open_row <= addr;
                if (cyc - last_ref[addr] > LIMIT) begin
                    mem[addr]      <= ~mem[addr];
                    corrupt_events <= corrupt_events + 1;
                end
                last_ref[addr] <= cyc;
            end
            if (cas_p && !cas_n && !we_n) begin
                mem[open_row][addr] <= din;
            end
        end
    end

    assign dout = cas_n ? 1'b0 : mem[open_row][addr];

endmodule

// File: tb/dramc_tb_top.sv
module dramc_tb_top;

    localparam int     REF_IV = 24;
    localparam longint LIMIT  = longint'(REF_IV) * 256 + 64;
    localparam int     WD_CYC = 150000;
    localparam int     NVEC   = 14;

    // Vector fields: {write, data, expected read, address[15:0]}
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b1, 1'b1, 1'b0, 16'h0000},
        {1'b1, 1'b1, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 1'b0, 16'h00FF},
        {1'b1, 1'b0, 1'b0, 16'hFF00},
        {1'b1, 1'b1, 1'b0, 16'h1234},
        {1'b1, 1'b0, 1'b0, 16'h3412},
        {1'b0, 1'b0, 1'b1, 16'h0000},
        {1'b0, 1'b0, 1'b1, 16'hFFFF},
        {1'b0, 1'b0, 1'b1, 16'h00FF},
        {1'b0, 1'b0, 1'b0, 16'hFF00},
        {1'b0, 1'b0, 1'b1, 16'h1234},
        {1'b0, 1'b0, 1'b0, 16'h3412},
        {1'b1, 1'b0, 1'b0, 16'h0000},
        {1'b0, 1'b0, 1'b0, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write, req_wdata;
    logic [15:0] req_addr;
    logic        req_ready, rsp_valid, rsp_rdata;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;
    int          corrupt_events;

    always #4 clk = ~clk;   // 8 ns period

    dramc_top #(.ROW_BITS(8), .REF_INTERVAL(REF_IV)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_din(dram_din), .dram_dout(dram_dout)
    );

    dramc_array_model #(.ROW_BITS(8), .LIMIT(LIMIT)) mdl_i (
        .clk(clk), .rst_n(rst_n), .addr(dram_addr), .ras_n(dram_ras_n),
        .cas_n(dram_cas_n), .we_n(dram_we_n), .din(dram_din), .dout(dram_dout),
        .corrupt_events(corrupt_events)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pin monitor, sampled on the falling edge.
    longint     cyc = 0;
    always @(posedge clk) cyc++;

    bit         ras_prev = 1'b1, cas_prev = 1'b1, saw_cas = 1'b0, ras_fall_valid = 1'b0;
    logic [7:0] cur_row = '0, host_row = '0, host_col = '0, last_ref_row = '0;
    bit         host_we = 1'b1, host_din = 1'b0;
    int         ref_count = 0, ref_step_err = 0, ready_in_ras = 0, prio_seen = 0;
    int         first_ref_row = -1;
    longint     ras_fall_cyc = 0, last_ref_fall = 0, ref_gap = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ras_prev && !dram_ras_n) begin
                cur_row        = dram_addr;
                saw_cas        = 1'b0;
                ras_fall_cyc   = cyc;
                ras_fall_valid = req_valid;
            end
            if (cas_prev && !dram_cas_n) begin
                saw_cas  = 1'b1;
                host_row = cur_row;
                host_col = dram_addr;
                host_we  = dram_we_n;
                host_din = dram_din;
            end
            if (!ras_prev && dram_ras_n && !saw_cas) begin
                if (ref_count == 0) first_ref_row = int'(cur_row);
                else if (cur_row != last_ref_row + 8'd1) ref_step_err++;
                ref_gap       = ras_fall_cyc - last_ref_fall;
                last_ref_fall = ras_fall_cyc;
                last_ref_row  = cur_row;
                ref_count++;
                if (ras_fall_valid) prio_seen++;
            end
            if (!dram_ras_n && req_ready) ready_in_ras++;
        end
        ras_prev = dram_ras_n;
        cas_prev = dram_cas_n;
    end

    task automatic host_op(input bit wr, input logic [15:0] a, input bit d,
                           input bit wait_idle, output bit got, output bit rd);
        got = 1'b0;
        rd  = 1'b0;
        @(posedge clk); #2;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(posedge clk); #2;
        req_valid = 1'b0;
        if (!wr) begin
            @(negedge clk);
            while (!rsp_valid) @(negedge clk);
            got = 1'b1;
            rd  = rsp_rdata;
        end
        if (wait_idle) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
        end
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [18:0] v;
    logic [7:0]  r8;
    logic [15:0] a;
    bit          got, rd, d;
    int          heavy_err = 0, keep_err = 0;

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = 1'b0;
        repeat (5) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(dram_ras_n == 1'b1, "R1", "ras_n after reset", int'(dram_ras_n), 1);
        check(dram_cas_n == 1'b1, "R1", "cas_n after reset", int'(dram_cas_n), 1);
        check(dram_we_n  == 1'b1, "R1", "we_n after reset", int'(dram_we_n), 1);
        check(req_ready  == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(rsp_valid  == 1'b0, "R1", "rsp_valid after reset", int'(rsp_valid), 0);

        // R7 idle refresh cadence and row order
        while (ref_count < 3) @(negedge clk);
        check(first_ref_row == 0, "R7", "first refresh row", first_ref_row, 0);
        check(ref_gap == longint'(REF_IV), "R7", "idle refresh spacing", int'(ref_gap), REF_IV);
        check(ref_step_err == 0, "R7", "refresh row steps", ref_step_err, 0);

        // Vector table: pin order (R2, R3), direction (R4), read data (R5)
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            host_op(v[18], v[15:0], v[17], 1'b1, got, rd);
            check(host_row == v[7:0], "R2", "row byte at row strobe", int'(host_row), int'(v[7:0]));
            check(host_col == v[15:8], "R3", "column byte at column strobe", int'(host_col), int'(v[15:8]));
            check(host_we == ~v[18], "R4", "we_n at column strobe", int'(host_we), int'(~v[18]));
            if (v[18]) begin
                check(host_din == v[17], "R4", "din at column strobe", int'(host_din), int'(v[17]));
            end else begin
                check(got && rd == v[16], "R5", "read data", int'(rd), int'(v[16]));
            end
        end

        // R5 hold: rsp_rdata (now 0) is unchanged by a write
        host_op(1'b1, 16'h0000, 1'b1, 1'b1, got, rd);
        check(rsp_rdata == 1'b0, "R5", "read data held across write", int'(rsp_rdata), 0);
        host_op(1'b0, 16'h0000, 1'b0, 1'b1, got, rd);
        check(got && rd == 1'b1, "R5", "read after overwrite", int'(rd), 1);

        // R9: one bit per row, then traffic confined to rows 0..3
        for (int r = 0; r < 256; r++) begin
            r8 = r[7:0];
            host_op(1'b1, {r8 ^ 8'h5A, r8}, r8[0] ^ r8[3], 1'b0, got, rd);
        end
        for (int i = 0; i < 800; i++) begin
            a = {8'h80 | 8'(i[6:0]), 6'b0, i[1:0]};
            d = i[2] ^ i[7];
            host_op(1'b1, a, d, 1'b0, got, rd);
            host_op(1'b0, a, 1'b0, 1'b0, got, rd);
            if (!got || rd != d) heavy_err++;
        end
        for (int r = 0; r < 256; r++) begin
            r8 = r[7:0];
            host_op(1'b0, {r8 ^ 8'h5A, r8}, 1'b0, 1'b0, got, rd);
            if (!got || rd != (r8[0] ^ r8[3])) keep_err++;
        end
        repeat (20) @(negedge clk);

        check(heavy_err == 0, "R9", "traffic read mismatches", heavy_err, 0);
        check(keep_err == 0, "R9", "untouched rows lost data", keep_err, 0);
        check(corrupt_events == 0, "R9", "rows past refresh limit", corrupt_events, 0);
        check(ref_step_err == 0, "R7", "refresh row steps under traffic", ref_step_err, 0);
        check(ready_in_ras == 0, "R6", "ready while row strobe low", ready_in_ras, 0);
        check(prio_seen > 0, "R8", "refresh ahead of waiting request", prio_seen, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule